// File: doc/BRIEF.md
# Boot Reset Release Sequencer

This block produces the internal reset of a small processor core and runs its first boot step. It accepts two reset sources: an external active-low reset pin and a watchdog reset request. Releasing them does not let the core run. The block first waits a fixed number of clock cycles so the on-chip oscillator can settle. It then reads one word from memory at the vector table base and hands that word to the core as its program counter.

The pin drives the internal reset low immediately, without waiting for a clock edge. The internal reset returns high only through a synchronizer clocked by the internal oscillator. A watchdog request, which is already synchronous to that clock, clears the same synchronizer at a clock edge. The block also drives a register-clear strobe for the core's register file. While that strobe is high, the eight general registers, the status register and the stack pointer are held at zero. A status register of zero means interrupt level 0 with interrupts disabled.

If either source asserts again before booting has finished, the whole sequence starts over. The memory and the execution of instructions are outside this block.

Top module: `boot_reset_seq`

## Requirements
- R1: While the reset pin is low, `int_rst_n` is low with no clock edge needed. Once at least one clock edge has passed in reset, `mem_req`, `pc_load` and `boot_done` are 0 and `pc_value` is zero.
- R2: After the reset pin goes high (with no watchdog request), `int_rst_n` stays low through the first rising clock edge and goes high on the second.
- R3: A watchdog request sampled high at a clock edge drives `int_rst_n` low right after that edge, and `boot_done` drops with it. Once the request is sampled low, release follows the same two-edge rule as R2.
- R4: `mem_req` first goes high exactly STAB_CYCLES rising edges after `int_rst_n` rises (64 by default).
- R5: While `mem_req` is high, `mem_addr` equals the VEC_BASE parameter. `mem_req` stays high until `mem_rvalid` is sampled high.
- R6: At the edge where `mem_req` and `mem_rvalid` are both high, `pc_value` takes `mem_rdata`, `pc_load` is high for the following cycle only, and `mem_req` drops.
- R7: `boot_done` rises one cycle after `pc_load` and stays high until a reset source asserts.
- R8: If a reset source asserts during the stabilization wait or the vector fetch, the full STAB_CYCLES wait is repeated after the release.
- R9: `regs_clear` (zeroing R0 to R7, the status register and the stack pointer) is 1 exactly while `int_rst_n` is 0.
- R10: `mem_rvalid` has no effect outside a fetch. During the wait or after booting, `pc_value` is unchanged and `pc_load` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_rst_req | input | 1 | Watchdog reset request, active high, synchronous |
| mem_rdata | input | DATA_W | Read data returned by memory |
| mem_rvalid | input | 1 | Read data valid |
| int_rst_n | output | 1 | Internal reset, active low |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | ADDR_W | Vector read address |
| pc_load | output | 1 | One-cycle strobe: load `pc_value` into the PC |
| pc_value | output | DATA_W | Fetched reset vector |
| regs_clear | output | 1 | Hold register file, status and stack pointer at zero |
| boot_done | output | 1 | Boot sequence complete, core may run |

## Verification
The bound checker checks the following on every cycle:
- the outputs are quiet while the internal reset is low;
- the address is fixed whenever a request is up, and the request holds until the handshake;
- a single-cycle load strobe carries the handshaked data;
- completion follows the load and stays high;
- a watchdog request drops the reset at the next edge;
- the first request comes exactly STAB_CYCLES edges after release.

Some behaviour only the bench scenarios can show:
- the two-edge release after the pin or the watchdog;
- the asynchronous drop in the middle of a cycle;
- a full restart after a reset in the middle of the wait or the fetch;
- stray valid strobes that leave the program counter untouched;
- correct vector capture across several data words and memory latencies.

// File: rtl/boot_seq_pkg.sv
// Shared types for the boot reset sequencer.
// Assumes: no other package defines the same names.
package boot_seq_pkg;

    // Phase of the vector fetch once the internal reset is released.
    typedef enum logic [1:0] {
        BOOT_ARMED = 2'd0,   // waiting for stabilization, then fetching
        BOOT_LOAD  = 2'd1,   // vector captured, PC load strobe
        BOOT_DONE  = 2'd2    // core released
    } boot_state_e;

endpackage

// File: rtl/boot_rst_sync.sv
// Reset synchronizer for the external pin combined with the watchdog request.
// What it does: the pin clears the chain asynchronously, and ones shift in on clock edges.
// The watchdog request clears the chain synchronously.
// Assumes: STAGES >= 2, and wdt_req is synchronous to clk.
module boot_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    input  logic wdt_req,
    output logic rst_n
);

    logic [STAGES-1:0] chain_q;

    // Asynchronous assertion from the pin, synchronous clear from the watchdog, synchronous release.
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            chain_q <= '0;
        end else if (wdt_req) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/boot_stab_timer.sv
// Oscillator stabilization timer.
// What it does: counts rising edges after the internal reset releases and sets a
// sticky flag once STAB_CYCLES edges have passed.
// Assumes: STAB_CYCLES >= 1, and rst_n is synchronous active low.
module boot_stab_timer #(
    parameter int STAB_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired
);

    localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             expired_q;

    // Count edges until the limit is reached, then hold the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            expired_q <= 1'b0;
        end else if (!expired_q) begin
            if (cnt_q == CNT_W'(STAB_CYCLES - 1)) begin
                expired_q <= 1'b1;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = expired_q;

endmodule

// File: rtl/boot_vec_fetch.sv
// Reset vector fetch state machine.
// What it does: once `start` is high, requests a read, captures the returned word
// on the valid handshake, pulses the load strobe, then reports done.
// Assumes: rst_n is synchronous active low, and start is sticky until reset.
module boot_vec_fetch
    import boot_seq_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rvalid,
    output logic              req,
    output logic              load,
    output logic [DATA_W-1:0] pc,
    output logic              done
);

    boot_state_e       state_q;
    logic [DATA_W-1:0] pc_q;

    // Advance the fetch phases and capture the vector on the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BOOT_ARMED;
            pc_q    <= '0;
        end else begin
            unique case (state_q)
                BOOT_ARMED: begin
                    if (start && rvalid) begin
                        pc_q    <= rdata;
                        state_q <= BOOT_LOAD;
                    end
                end
                BOOT_LOAD: state_q <= BOOT_DONE;
                BOOT_DONE: state_q <= BOOT_DONE;
                default:   state_q <= BOOT_ARMED;
            endcase
        end
    end

    // Decode the outputs from the current phase.
    always_comb begin
        req  = (state_q == BOOT_ARMED) && start;
        load = (state_q == BOOT_LOAD);
        done = (state_q == BOOT_DONE);
    end

    assign pc = pc_q;

endmodule

// File: rtl/boot_reset_seq.sv
// Boot reset release sequencer (top).
// What it does: combines the reset pin and the watchdog request into the internal reset,
// waits STAB_CYCLES edges, fetches the reset vector from VEC_BASE and releases the core.
// Assumes: one clock domain (the internal oscillator), and memory answers with a valid strobe.
module boot_reset_seq #(
    parameter int                 ADDR_W      = 24,
    parameter int                 DATA_W      = 24,
    parameter int                 STAB_CYCLES = 64,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0]  VEC_BASE    = '0
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic              wdt_rst_req,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              int_rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              pc_load,
    output logic [DATA_W-1:0] pc_value,
    output logic              regs_clear,
    output logic              boot_done
);

    logic sync_rst_n;
    logic stab_expired;
    logic fetch_req;
    logic fetch_load;
    logic fetch_done;

    boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .pin_n   (rst_pin_n),
        .wdt_req (wdt_rst_req),
        .rst_n   (sync_rst_n)
    );

    boot_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk     (clk),
        .rst_n   (sync_rst_n),
        .expired (stab_expired)
    );

    boot_vec_fetch #(.DATA_W(DATA_W)) u_fetch (
        .clk    (clk),
        .rst_n  (sync_rst_n),
        .start  (stab_expired),
        .rdata  (mem_rdata),
        .rvalid (mem_rvalid),
        .req    (fetch_req),
        .load   (fetch_load),
        .pc     (pc_value),
        .done   (fetch_done)
    );

    // Gate every strobe with the internal reset so that an asynchronous pin assertion silences them at once.
    always_comb begin
        int_rst_n  = sync_rst_n;
        regs_clear = !sync_rst_n;
        mem_req    = sync_rst_n && fetch_req;
        pc_load    = sync_rst_n && fetch_load;
        boot_done  = sync_rst_n && fetch_done;
        mem_addr   = mem_req ? VEC_BASE : '0;
    end

endmodule

// File: rtl/boot_reset_seq_chk.sv
// Property checker for boot_reset_seq, attached with bind.
// What it does: watches the top-level ports over time.
// It uses its own counter to check the length of the stabilization wait.
module boot_reset_seq_chk #(
    parameter int                ADDR_W      = 24,
    parameter int                DATA_W      = 24,
    parameter int                STAB_CYCLES = 64,
    parameter logic [ADDR_W-1:0] VEC_BASE    = '0
) (
    input logic              clk,
    input logic              rst_pin_n,
    input logic              wdt_rst_req,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              mem_rvalid,
    input logic              int_rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pc_load,
    input logic [DATA_W-1:0] pc_value,
    input logic              regs_clear,
    input logic              boot_done
);

    localparam int SW = $clog2(STAB_CYCLES + 1) + 1;
    logic [SW-1:0] since_q;

    // Count edges since the release, saturating at the wait length.
    always_ff @(posedge clk) begin
        if (!int_rst_n) since_q <= '0;
        else if (since_q < SW'(STAB_CYCLES)) since_q <= since_q + 1'b1;
    end

    // Nothing may be active while the internal reset is low.
    always_comb begin
        if (!int_rst_n) begin
            AST_QUIET_IN_RESET: assert (!mem_req && !pc_load && !boot_done && regs_clear); // R1
        end
    end

    AST_WDT_DROPS_RESET: assert property (@(posedge clk) disable iff (!rst_pin_n)
        wdt_rst_req |=> !int_rst_n); // R3

    AST_STAB_LENGTH: assert property (@(posedge clk) disable iff (!int_rst_n)
        $rose(mem_req) |-> since_q == SW'(STAB_CYCLES)); // R4

    AST_REQ_ADDR: assert property (@(posedge clk) disable iff (!int_rst_n)
        mem_req |-> mem_addr == VEC_BASE); // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!int_rst_n)
        mem_req && !mem_rvalid |=> mem_req); // R5

    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!int_rst_n)
        mem_req && mem_rvalid |=> pc_load && !mem_req && pc_value == $past(mem_rdata)); // R6

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!int_rst_n)
        pc_load |=> !pc_load); // R6

    AST_DONE_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!int_rst_n)
        pc_load |=> boot_done); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!int_rst_n)
        boot_done |=> boot_done); // R7

endmodule

bind boot_reset_seq boot_reset_seq_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STAB_CYCLES (STAB_CYCLES),
    .VEC_BASE    (VEC_BASE)
) u_chk (
    .clk         (clk),
    .rst_pin_n   (rst_pin_n),
    .wdt_rst_req (wdt_rst_req),
    .mem_rdata   (mem_rdata),
    .mem_rvalid  (mem_rvalid),
    .int_rst_n   (int_rst_n),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .pc_load     (pc_load),
    .pc_value    (pc_value),
    .regs_clear  (regs_clear),
    .boot_done   (boot_done)
);

// File: tb/boot_reset_seq_test.sv
module boot_reset_seq_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 24;
    localparam int          DW         = 24;
    localparam int          STAB       = 64;
    localparam logic [23:0] VBASE      = 24'h000400;

    // Each entry: {rvalid delay[3:0], vector word[23:0]}
    localparam logic [27:0] VEC_TBL [0:3] = '{
        {4'd0, 24'h00A5C3},
        {4'd1, 24'hFFFFFF},
        {4'd3, 24'h000000},
        {4'd7, 24'h123456}
    };

    logic          clk = 1'b0;
    logic          rst_pin_n;
    logic          wdt_rst_req;
    logic [DW-1:0] mem_rdata;
    logic          mem_rvalid;
    logic          int_rst_n;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          pc_load;
    logic [DW-1:0] pc_value;
    logic          regs_clear;
    logic          boot_done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_reset_seq #(
        .ADDR_W(AW), .DATA_W(DW), .STAB_CYCLES(STAB), .SYNC_STAGES(2), .VEC_BASE(VBASE)
    ) uut (
        .clk(clk), .rst_pin_n(rst_pin_n), .wdt_rst_req(wdt_rst_req),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .int_rst_n(int_rst_n),
        .mem_req(mem_req), .mem_addr(mem_addr), .pc_load(pc_load),
        .pc_value(pc_value), .regs_clear(regs_clear), .boot_done(boot_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Hold the pin low for a few cycles, then release it at a falling edge.
    task automatic pin_reset();
        @(negedge clk);
        rst_pin_n = 1'b0;
        #1;
        chk("R1 async assert", {31'd0, int_rst_n}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R1 no request", {31'd0, mem_req}, 32'd0);
        chk("R1 no done", {31'd0, boot_done}, 32'd0);
        chk("R1 pc cleared", {8'd0, pc_value}, 32'd0);
        chk("R9 clear in reset", {31'd0, regs_clear}, 32'd1);
        rst_pin_n = 1'b1;
    endtask

    // Called at the falling edge where the last source was dropped.
    task automatic release_and_stab(input bit stray);
        int n;
        @(negedge clk);
        chk("R2 low after first edge", {31'd0, int_rst_n}, 32'd0);
        @(negedge clk);
        chk("R2 high after second edge", {31'd0, int_rst_n}, 32'd1);
        chk("R9 clear released", {31'd0, regs_clear}, 32'd0);
        if (stray) begin
            mem_rdata  = 24'h5A5A5A;
            mem_rvalid = 1'b1;
        end
        n = 0;
        while (!mem_req && n < 300) begin
            @(negedge clk);
            n++;
            if (stray && !mem_req) begin
                chk("R10 no load during wait", {31'd0, pc_load}, 32'd0);
            end
        end
        chk("R4 wait length", n, STAB);
        if (stray) begin
            chk("R10 pc untouched in wait", {8'd0, pc_value}, 32'd0);
            mem_rvalid = 1'b0;
        end
    endtask

    // Called at the falling edge where mem_req is first high.
    task automatic finish_fetch(input logic [DW-1:0] data, input int delay);
        chk("R5 address", {8'd0, mem_addr}, {8'd0, VBASE});
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk("R5 request held", {31'd0, mem_req}, 32'd1);
        end
        mem_rdata  = data;
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk("R6 load strobe", {31'd0, pc_load}, 32'd1);
        chk("R6 pc value", {8'd0, pc_value}, {8'd0, data});
        chk("R6 request dropped", {31'd0, mem_req}, 32'd0);
        chk("R7 not yet done", {31'd0, boot_done}, 32'd0);
        @(negedge clk);
        chk("R6 strobe single", {31'd0, pc_load}, 32'd0);
        chk("R7 done rises", {31'd0, boot_done}, 32'd1);
        @(negedge clk);
        chk("R7 done holds", {31'd0, boot_done}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_pin_n   = 1'b0;
        wdt_rst_req = 1'b0;
        mem_rdata   = '0;
        mem_rvalid  = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset state", {31'd0, int_rst_n}, 32'd0);
        chk("R9 reset clear", {31'd0, regs_clear}, 32'd1);

        // Table: cold boots with varied vectors and memory latency
        for (int k = 0; k < 4; k++) begin
            pin_reset();
            release_and_stab(1'b0);
            finish_fetch(VEC_TBL[k][23:0], int'(VEC_TBL[k][27:24]));
        end

        // R8 and R3: watchdog request in the middle of the wait restarts the wait
        pin_reset();
        @(negedge clk);
        @(negedge clk);
        repeat (20) @(negedge clk);
        wdt_rst_req = 1'b1;
        @(negedge clk);
        chk("R3 watchdog drops reset", {31'd0, int_rst_n}, 32'd0);
        chk("R8 no request after wdt", {31'd0, mem_req}, 32'd0);
        wdt_rst_req = 1'b0;
        release_and_stab(1'b0);
        finish_fetch(24'h0BEEF0, 2);

        // R8 and R1: pin asserted in the middle of a fetch
        pin_reset();
        release_and_stab(1'b0);
        repeat (2) @(negedge clk);
        #2 rst_pin_n = 1'b0;
        #1;
        chk("R1 async drop in fetch", {31'd0, int_rst_n}, 32'd0);
        chk("R1 request cut", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        rst_pin_n = 1'b1;
        release_and_stab(1'b0);
        finish_fetch(24'h777001, 0);

        // R10: stray valid during the wait, then after booting
        pin_reset();
        release_and_stab(1'b1);
        finish_fetch(24'h13579B, 1);
        mem_rdata  = 24'hC0FFEE;
        mem_rvalid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 pc kept after boot", {8'd0, pc_value}, 32'h0013579B);
        chk("R10 no load after boot", {31'd0, pc_load}, 32'd0);
        mem_rvalid = 1'b0;

        // R3: watchdog after booting takes the core back to reset
        wdt_rst_req = 1'b1;
        @(negedge clk);
        chk("R3 done drops", {31'd0, boot_done}, 32'd0);
        chk("R9 clear on wdt", {31'd0, regs_clear}, 32'd1);
        wdt_rst_req = 1'b0;
        release_and_stab(1'b0);
        finish_fetch(24'h2468AC, 4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule